// File: doc/BRIEF.md
# Page Buffer Serial Command Front-End

This block is the slave side of a serial command port for a page-organised data memory. The host lowers chip select and clocks in an 8-bit command code, then three address bytes, then data. All fields travel most significant bit first. The block keeps a 264-byte buffer, one page of 256 data bytes plus 8 spare bytes. It can fill the buffer from the serial input and stream the buffer back on the serial output. Sequential bytes step through the buffer and wrap from the last byte to byte 0.

Two read commands are offered, and they differ only in the clock edge on which output bits change. The trailing-edge read changes data on falling edges, so the host samples on rising edges (SPI modes 0 and 3). The leading-edge read changes data on rising edges, so the host samples on falling edges. The serial clock is oversampled by the system clock, so either idle level of the serial clock is accepted. Raising chip select ends any command at once.

Top module: `pagebuf_spi_front`

## Requirements
- R1: After reset the output enable `so_oe` is low and `so` is high.
- R2: Command code 0x84 writes the buffer. Input bits are taken on rising `sck` edges while `cs_n` is low, MSB first. Three address bytes follow the code, and the low 9 bits of those 24 bits form the byte address (bit 8 is bit 0 of the second address byte). Each following data byte is stored at the current byte address.
- R3: Command code 0xD4 reads the buffer. One dummy byte follows the address, then buffer bytes are sent MSB first on `so`, changing only on falling `sck` edges.
- R4: Command code 0x54 reads the buffer in the same way as R3, except that `so` changes only on rising `sck` edges.
- R5: After each data byte, whether written or read, the byte address advances by one and goes from 263 to 0.
- R6: At a byte address of 264 or more, a write stores nothing and a read returns 0xFF. The next address after any such address is 0.
- R7: An unrecognised command code is ignored until `cs_n` rises: `so_oe` stays low and the buffer is unchanged.
- R8: When `cs_n` goes high, `so_oe` drops in the same cycle and the command ends. A partly shifted byte is discarded, and the next command starts at bit 0 of a new command code.
- R9: If `cs_n` rises in the same system clock cycle as the eighth rising `sck` edge of a data byte, the command ends and that byte is not written.
- R10: Commands work whether `sck` idles low or idles high while `cs_n` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low, synchronous to `clk` |
| sck | input | 1 | Serial clock, synchronous to `clk` |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | High while `so` should be driven |

## Verification
A single system clock cycle can contain both the eighth rising serial clock edge of a data byte, which commits the byte to the buffer, and the rise of chip select, which ends the command. The bench provokes this by raising `sck` and `cs_n` at the same clock edge during a write to an address that already holds a known value. It then reads that address back. The old value must be returned, and a following write to another address must land intact, which shows the bit counter was cleared.

// File: rtl/pagebuf_spi_front.sv
module pagebuf_spi_front #(
  parameter int DEPTH = 264,
  parameter logic [7:0] OP_WR = 8'h84,
  parameter logic [7:0] OP_RD_TRAIL = 8'hD4,
  parameter logic [7:0] OP_RD_LEAD = 8'h54
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  output logic so,
  output logic so_oe
);
  localparam int AW = $clog2(DEPTH);

  typedef enum logic [2:0] {P_OP, P_A1, P_A2, P_A3, P_DUMMY, P_DATA, P_IGN} phase_t;

  phase_t phase;
  logic sck_q, so_r;
  logic [2:0] bitcnt;
  logic [7:0] sh, op, cur;
  logic [AW-1:0] addr;
  logic [7:0] mem [DEPTH];

  wire rise = sck & ~sck_q & ~cs_n;
  wire fall = ~sck & sck_q & ~cs_n;
  wire [7:0] rx = {sh[6:0], si};
  wire done = rise && bitcnt == 3'd7;
  wire is_rd = (op == OP_RD_TRAIL) || (op == OP_RD_LEAD);
  wire in_rng = int'(addr) < DEPTH;
  wire [AW-1:0] addr_nx = (int'(addr) >= DEPTH - 1) ? '0 : addr + 1'b1;
  wire [7:0] rd_byte = in_rng ? mem[addr] : 8'hFF;
  wire shift_out = phase == P_DATA &&
                   ((op == OP_RD_TRAIL && fall) || (op == OP_RD_LEAD && rise));
  wire wr_en = done && phase == P_DATA && op == OP_WR && in_rng;

  assign so = so_r;
  assign so_oe = ~cs_n & is_rd & (phase == P_DATA);

  always_ff @(posedge clk)
    if (wr_en) mem[addr] <= rx;

  always_ff @(posedge clk) begin
    sck_q <= sck;
    if (rst) so_r <= 1'b1;
    else if (shift_out) so_r <= cur[~bitcnt];
    if (rst || cs_n) begin
      bitcnt <= '0;
      phase <= P_OP;
      op <= '0;
    end else begin
      if (rise) begin
        sh <= rx;
        bitcnt <= bitcnt + 1'b1;
      end
      if (done) begin
        case (phase)
          P_OP: begin
            op <= rx;
            phase <= (rx == OP_WR || rx == OP_RD_TRAIL || rx == OP_RD_LEAD) ? P_A1 : P_IGN;
          end
          P_A1: phase <= P_A2;
          P_A2: begin
            addr[AW-1] <= rx[0];
            phase <= P_A3;
          end
          P_A3: begin
            addr[7:0] <= rx;
            phase <= (op == OP_WR) ? P_DATA : P_DUMMY;
          end
          P_DUMMY: begin
            cur <= rd_byte;
            addr <= addr_nx;
            phase <= P_DATA;
          end
          P_DATA: begin
            if (is_rd) cur <= rd_byte;
            addr <= addr_nx;
          end
          default: phase <= P_IGN;
        endcase
      end
    end
  end

  AST_CS_CLEARS: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> (bitcnt == 3'd0 && phase == P_OP)); // R8
  AST_IGN_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (phase == P_IGN && !cs_n) |=> phase == P_IGN); // R7
  AST_ADDR_WRAP: assert property (@(posedge clk) disable iff (rst)
    (done && (phase == P_DATA || phase == P_DUMMY) && int'(addr) >= DEPTH - 1) |=> addr == '0); // R5
  AST_TRAIL_EDGE: assert property (@(posedge clk) disable iff (rst)
    (op == OP_RD_TRAIL && !fall) |=> $stable(so)); // R3
  AST_LEAD_EDGE: assert property (@(posedge clk) disable iff (rst)
    (op == OP_RD_LEAD && !rise) |=> $stable(so)); // R4
endmodule

// File: tb/tb_pagebuf_spi_front.sv
module tb_pagebuf_spi_front;
  logic clk = 1'b0, rst = 1'b1, cs_n = 1'b1, sck = 1'b0, si = 1'b0;
  logic so, so_oe;
  logic idle = 1'b0;
  logic [7:0] rxb;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  pagebuf_spi_front dut (.clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .si(si), .so(so), .so_oe(so_oe));

  localparam logic [16:0] VEC [6] = '{
    {9'd0, 8'hA5}, {9'd1, 8'h3C}, {9'd100, 8'h81},
    {9'd255, 8'h00}, {9'd256, 8'hFF}, {9'd263, 8'h5E}};

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] tx, input bit lead);
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk) si = tx[i]; sck = 1'b0;
      repeat (2) @(negedge clk);
      if (!lead) rxb[i] = so;
      sck = 1'b1;
      repeat (2) @(negedge clk);
      if (lead) rxb[i] = so;
      sck = 1'b0;
    end
  endtask

  task automatic start(input logic [7:0] op, input logic [8:0] a);
    @(negedge clk) sck = idle;
    @(negedge clk) cs_n = 1'b0;
    @(negedge clk);
    xfer(op, 0); xfer(8'h00, 0); xfer({7'b0, a[8]}, 0); xfer(a[7:0], 0);
  endtask

  task automatic stop();
    @(negedge clk) cs_n = 1'b1;
    @(negedge clk) sck = idle;
    @(negedge clk);
  endtask

  task automatic wr1(input logic [8:0] a, input logic [7:0] d);
    start(8'h84, a); xfer(d, 0); stop();
  endtask

  task automatic rd1(input logic [8:0] a, input bit lead, output logic [7:0] d);
    start(lead ? 8'h54 : 8'hD4, a); xfer(8'h00, 0); xfer(8'h00, lead); d = rxb; stop();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 so_oe after reset", {7'b0, so_oe}, 8'h00);
    chk("R1 so after reset", {7'b0, so}, 8'h01);

    foreach (VEC[i]) wr1(VEC[i][16:8], VEC[i][7:0]);
    foreach (VEC[i]) begin
      rd1(VEC[i][16:8], i % 2 == 1, d);
      chk((i % 2 == 1) ? "R2 R4 lead read" : "R2 R3 trail read", d, VEC[i][7:0]);
    end

    start(8'h84, 9'd262); xfer(8'h11, 0); xfer(8'h22, 0); xfer(8'h33, 0); stop();
    start(8'hD4, 9'd262); xfer(8'h00, 0);
    xfer(8'h00, 0); chk("R5 byte 262", rxb, 8'h11);
    chk("R3 so_oe during read", {7'b0, so_oe}, 8'h01);
    xfer(8'h00, 0); chk("R5 byte 263", rxb, 8'h22);
    xfer(8'h00, 0); chk("R5 wrapped byte 0", rxb, 8'h33);
    @(negedge clk) cs_n = 1'b1;
    #1 chk("R8 so_oe drops with cs_n", {7'b0, so_oe}, 8'h00);
    @(negedge clk) sck = idle;

    start(8'h84, 9'd300); xfer(8'h77, 0); xfer(8'h99, 0); stop();
    rd1(9'd300, 0, d); chk("R6 out of range read", d, 8'hFF);
    rd1(9'd0, 1, d); chk("R6 next address is 0", d, 8'h99);

    wr1(9'd5, 8'h42);
    start(8'h00, 9'd5); xfer(8'hEE, 0);
    chk("R7 so_oe low on unknown code", {7'b0, so_oe}, 8'h00);
    stop();
    rd1(9'd5, 0, d); chk("R7 buffer unchanged", d, 8'h42);

    start(8'h84, 9'd5);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk) si = 1'b0; repeat (2) @(negedge clk); sck = 1'b1; repeat (2) @(negedge clk); sck = 1'b0;
    end
    stop();
    rd1(9'd5, 0, d); chk("R8 partial byte dropped", d, 8'h42);
    wr1(9'd6, 8'h6B);
    rd1(9'd6, 1, d); chk("R8 next command aligned", d, 8'h6B);

    start(8'h84, 9'd5);
    for (int i = 7; i >= 1; i--) begin
      @(negedge clk) si = 1'b1; repeat (2) @(negedge clk); sck = 1'b1; repeat (2) @(negedge clk); sck = 1'b0;
    end
    @(negedge clk) si = 1'b1; repeat (2) @(negedge clk);
    sck = 1'b1; cs_n = 1'b1;
    repeat (2) @(negedge clk); sck = idle;
    @(negedge clk);
    rd1(9'd5, 0, d); chk("R9 cs rise wins over last edge", d, 8'h42);
    wr1(9'd7, 8'h2D);
    rd1(9'd7, 0, d); chk("R9 counter cleared", d, 8'h2D);

    idle = 1'b1;
    @(negedge clk) sck = 1'b1;
    wr1(9'd8, 8'hC3);
    rd1(9'd8, 1, d); chk("R10 idle high lead read", d, 8'hC3);
    rd1(9'd8, 0, d); chk("R10 idle high trail read", d, 8'hC3);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule